// File: doc/BRIEF.md
# System Management Entry Controller

This block sits on the platform side of a processor's system management mode. When the platform raises a management request, the controller drives the interrupt line to the processor. It holds that line until the processor acknowledges with its active indication. Alongside the interrupt it asserts a cache-flush line when the management memory is cacheable or overlaps cacheable main memory. It also holds off the "external write buffers empty" indication until any bus cycle in flight has received its final ready.

While the processor's active indication is high, the controller steers accesses that fall inside the 64 KB management window to management memory. The window may sit at its default page or at a relocated page. The controller drives the cache-enable line from the window's configured cacheability. Outside management mode it leaves addresses alone, so a relocated window reads as main memory and cache enable follows the ordinary main-memory decode.

Top module: `smm_entry_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `smi_o` and `flush_o` are low and `ewbe_o` is high.
- R2: The controller accepts a request when it is idle, `smm_req` is high and `smm_act` is low. `smi_o` rises on the following clock edge. It stays high until a clock edge at which `smm_act` is sampled high, and falls at that edge.
- R3: A request presented while `smm_act` is high is ignored: `smi_o` stays low.
- R4: `flush_o` is high exactly while `smi_o` is high and at least one of `cfg_overlap` or `cfg_cacheable` is high.
- R5: If no bus cycle is in flight when the request is accepted, `ewbe_o` is high in the same cycle in which `smi_o` first goes high.
- R6: A single-transfer bus cycle is started by `bus_start` with `bus_burst` low. If the request is accepted while such a cycle is in flight, `ewbe_o` is low from the rise of `smi_o` until the cycle's one `bus_rdy`. It is high in the cycle of that `bus_rdy` and afterwards.
- R7: A burst bus cycle is started by `bus_start` with `bus_burst` high and completes on its fourth `bus_rdy`. If the request is accepted while a burst is in flight, `ewbe_o` stays low through the first three `bus_rdy` and goes high with the fourth.
- R8: `smm_sel_o` is high only while `smm_act` is high and `addr_page` equals either 16'h0003 (the default window) or `cfg_base` (the relocated window).
- R9: While `smm_act` is low, `smm_sel_o` is low for every address and `ken_o` equals `norm_ken`, including for addresses in the relocated window.
- R10: When `cfg_cacheable` is low, `ken_o` is low while `smi_o` is high and for every access with `smm_sel_o` high. When `cfg_cacheable` is high, `ken_o` is high for every access with `smm_sel_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smm_req | input | 1 | Platform management request |
| smm_act | input | 1 | Processor's "in management mode" acknowledge |
| bus_start | input | 1 | Address strobe: a bus cycle starts |
| bus_burst | input | 1 | The starting cycle is a four-transfer burst |
| bus_rdy | input | 1 | Transfer ready |
| addr_page | input | 16 | Address bits above the 64 KB offset |
| cfg_base | input | 16 | Page of the relocated management window |
| cfg_cacheable | input | 1 | Management memory is cacheable |
| cfg_overlap | input | 1 | Management window overlaps cacheable main memory |
| norm_ken | input | 1 | Cache enable from the main-memory decode |
| smi_o | output | 1 | Management interrupt to the processor |
| flush_o | output | 1 | Cache flush request |
| ewbe_o | output | 1 | External write buffers empty |
| ken_o | output | 1 | Cache enable to the processor |
| smm_sel_o | output | 1 | 1 selects management memory, 0 selects main memory |

## Verification
Address steering is driven from a vector table in which the processor acknowledge, the cacheability strap and the address page vary independently. The table includes the default page, the relocated page, a neighbouring page on each side, and the relocated page outside management mode. These cases separate a decode that ignores the acknowledge, or that checks only one of the two windows, from the correct one. Entry is run three times: once with the bus idle, once with a single transfer in flight and once with a burst in flight. Comparing the three shows whether the write-buffer indication waits for exactly the completing ready rather than the first one. Requests made during the acknowledge, and each flush strap combination, show whether the interrupt and flush lines depend on state and configuration alone.

// File: rtl/smm_ctrl_pkg.sv
package smm_ctrl_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_REQ  = 2'd1,
    ENT_ACT  = 2'd2
  } ent_state_t;
endpackage

// File: rtl/smm_bus_tracker.sv
module smm_bus_tracker #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic bus_burst,
  input  logic bus_rdy,
  output logic busy_q,
  output logic busy_nx,
  output logic last_rdy
);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] BLEN = CW'(BURST_LEN);

  logic [CW-1:0] left_q, left_nx;

  assign last_rdy = busy_q && bus_rdy && (left_q == ONE);

  always_comb begin
    busy_nx = busy_q;
    left_nx = left_q;
    if (!busy_q && bus_start) begin
      busy_nx = 1'b1;
      left_nx = bus_burst ? BLEN : ONE;
    end else if (busy_q && bus_rdy) begin
      left_nx = left_q - ONE;
      if (left_q == ONE) busy_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_nx;
      left_q <= left_nx;
    end
  end

  p_done_on_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bus_rdy));
endmodule

// File: rtl/smm_entry_seq.sv
module smm_entry_seq
  import smm_ctrl_pkg::*;
#(
  parameter bit HAS_WBUF = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smm_req,
  input  logic smm_act,
  input  logic cfg_cacheable,
  input  logic cfg_overlap,
  input  logic bus_busy_nx,
  input  logic bus_last_rdy,
  output logic smi_o,
  output logic flush_o,
  output logic ewbe_o
);
  ent_state_t st_q, st_nx;
  logic accept;
  logic hold_q;

  assign accept = (st_q == ENT_IDLE) && smm_req && !smm_act;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ENT_IDLE: if (accept)   st_nx = ENT_REQ;
      ENT_REQ:  if (smm_act)  st_nx = ENT_ACT;
      ENT_ACT:  if (!smm_act) st_nx = ENT_IDLE;
      default:                st_nx = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ENT_IDLE;
    else        st_q <= st_nx;
  end

  assign smi_o   = (st_q == ENT_REQ);
  assign flush_o = smi_o && (cfg_overlap || cfg_cacheable);

  generate
    if (HAS_WBUF) begin : g_wbuf
      logic hold_nx;
      always_comb begin
        hold_nx = hold_q;
        if (accept)            hold_nx = bus_busy_nx;
        else if (bus_last_rdy) hold_nx = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_nx;
      end
    end else begin : g_nowbuf
      assign hold_q = 1'b0;
    end
  endgenerate

  assign ewbe_o = !hold_q || bus_last_rdy;

  p_smi_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o && !smm_act |=> smi_o);
  p_smi_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o && smm_act |=> !smi_o);
  p_ignore_in_smm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smm_act && !smi_o |=> !smi_o);
endmodule

// File: rtl/smm_addr_steer.sv
module smm_addr_steer #(
  parameter int PW = 16,
  parameter logic [PW-1:0] DEF_PAGE = 16'h0003
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [PW-1:0] addr_page,
  input  logic [PW-1:0] cfg_base,
  input  logic smm_act,
  input  logic smi,
  input  logic cfg_cacheable,
  input  logic norm_ken,
  output logic smm_sel,
  output logic ken
);
  logic in_def, in_reloc;

  assign in_def   = (addr_page == DEF_PAGE);
  assign in_reloc = (addr_page == cfg_base);
  assign smm_sel  = smm_act && (in_def || in_reloc);

  always_comb begin
    if (smm_sel)                    ken = cfg_cacheable;
    else if (smi && !cfg_cacheable) ken = 1'b0;
    else                            ken = norm_ken;
  end

  p_sel_needs_act_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smm_sel |-> smm_act);
endmodule

// File: rtl/smm_entry_ctrl.sv
module smm_entry_ctrl #(
  parameter int PW = 16,
  parameter int BURST_LEN = 4,
  parameter bit HAS_WBUF = 1'b1,
  parameter logic [PW-1:0] DEF_PAGE = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smm_req,
  input  logic          smm_act,
  input  logic          bus_start,
  input  logic          bus_burst,
  input  logic          bus_rdy,
  input  logic [PW-1:0] addr_page,
  input  logic [PW-1:0] cfg_base,
  input  logic          cfg_cacheable,
  input  logic          cfg_overlap,
  input  logic          norm_ken,
  output logic          smi_o,
  output logic          flush_o,
  output logic          ewbe_o,
  output logic          ken_o,
  output logic          smm_sel_o
);
  logic trk_busy, trk_busy_nx, trk_last;

  smm_bus_tracker #(.BURST_LEN(BURST_LEN)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .bus_start(bus_start), .bus_burst(bus_burst), .bus_rdy(bus_rdy),
    .busy_q(trk_busy), .busy_nx(trk_busy_nx), .last_rdy(trk_last)
  );

  smm_entry_seq #(.HAS_WBUF(HAS_WBUF)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .smm_req(smm_req), .smm_act(smm_act),
    .cfg_cacheable(cfg_cacheable), .cfg_overlap(cfg_overlap),
    .bus_busy_nx(trk_busy_nx), .bus_last_rdy(trk_last),
    .smi_o(smi_o), .flush_o(flush_o), .ewbe_o(ewbe_o)
  );

  smm_addr_steer #(.PW(PW), .DEF_PAGE(DEF_PAGE)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .addr_page(addr_page), .cfg_base(cfg_base),
    .smm_act(smm_act), .smi(smi_o),
    .cfg_cacheable(cfg_cacheable), .norm_ken(norm_ken),
    .smm_sel(smm_sel_o), .ken(ken_o)
  );

  p_ewbe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) && trk_busy && !trk_last |-> !ewbe_o);
  p_ken_noncache_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cacheable && (smi_o || smm_sel_o) |-> !ken_o);
endmodule

// File: tb/smm_entry_ctrl_tb.sv
module smm_entry_ctrl_tb;
  logic clk, rst_n;
  logic smm_req, smm_act, bus_start, bus_burst, bus_rdy;
  logic [15:0] addr_page, cfg_base;
  logic cfg_cacheable, cfg_overlap, norm_ken;
  logic smi_o, flush_o, ewbe_o, ken_o, smm_sel_o;
  int checks = 0;
  int errors = 0;

  smm_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .smm_req(smm_req), .smm_act(smm_act),
    .bus_start(bus_start), .bus_burst(bus_burst), .bus_rdy(bus_rdy),
    .addr_page(addr_page), .cfg_base(cfg_base),
    .cfg_cacheable(cfg_cacheable), .cfg_overlap(cfg_overlap),
    .norm_ken(norm_ken), .smi_o(smi_o), .flush_o(flush_o),
    .ewbe_o(ewbe_o), .ken_o(ken_o), .smm_sel_o(smm_sel_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {act, cacheable, page[15:0], norm_ken, exp_sel, exp_ken}
  localparam logic [20:0] VEC [0:7] = '{
    {1'b0, 1'b0, 16'h0003, 1'b1, 1'b0, 1'b1},  // R9 default page, not in SMM
    {1'b0, 1'b1, 16'hFE00, 1'b0, 1'b0, 1'b0},  // R9 relocated page, not in SMM
    {1'b1, 1'b0, 16'h0003, 1'b1, 1'b1, 1'b0},  // R8 R10 default page noncacheable
    {1'b1, 1'b1, 16'h0003, 1'b0, 1'b1, 1'b1},  // R8 R10 default page cacheable
    {1'b1, 1'b1, 16'hFE00, 1'b0, 1'b1, 1'b1},  // R8 relocated page
    {1'b1, 1'b0, 16'hFE01, 1'b1, 1'b0, 1'b1},  // R8 page above relocated
    {1'b1, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b0},  // R8 page below default
    {1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1}   // R9 low memory
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // accept a request with the bus idle, check the entry outputs, then acknowledge
  task automatic enter_idle(input logic exp_flush);
    smm_req = 1'b1;
    step(1);
    smm_req = 1'b0;
    check("R2 smi raised", smi_o, 1'b1);
    check("R4 flush with smi", flush_o, exp_flush);
    check("R5 ewbe with smi", ewbe_o, 1'b1);
    smm_act = 1'b1;
    step(1);
    check("R2 smi dropped", smi_o, 1'b0);
    check("R4 flush dropped", flush_o, 1'b0);
    smm_act = 1'b0;
    step(2);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    smm_req = 0; smm_act = 0; bus_start = 0; bus_burst = 0; bus_rdy = 0;
    addr_page = 16'h0000; cfg_base = 16'hFE00;
    cfg_cacheable = 0; cfg_overlap = 0; norm_ken = 1;
    step(2);
    check("R1 smi in reset", smi_o, 1'b0);
    check("R1 flush in reset", flush_o, 1'b0);
    check("R1 ewbe in reset", ewbe_o, 1'b1);
    rst_n = 1'b1;
    step(1);
    check("R1 smi after reset", smi_o, 1'b0);

    // steering table
    foreach (VEC[i]) begin
      smm_act = VEC[i][20];
      cfg_cacheable = VEC[i][19];
      addr_page = VEC[i][18:3];
      norm_ken = VEC[i][2];
      #1;
      check("R8 sel vector", smm_sel_o, VEC[i][1]);
      check("R9 R10 ken vector", ken_o, VEC[i][0]);
      step(1);
    end
    smm_act = 0; cfg_cacheable = 0; norm_ken = 1; addr_page = 16'h0000;
    step(2);

    // R2 hold until acknowledged, R10 ken low during smi
    smm_req = 1'b1;
    step(1);
    smm_req = 1'b0;
    check("R2 smi rose", smi_o, 1'b1);
    check("R10 ken low during smi", ken_o, 1'b0);
    step(2);
    check("R2 smi held without ack", smi_o, 1'b1);
    smm_act = 1'b1;
    #1;
    check("R2 smi before ack edge", smi_o, 1'b1);
    step(1);
    check("R2 smi fell after ack", smi_o, 1'b0);
    // R3 request during acknowledge ignored
    smm_req = 1'b1;
    step(1);
    check("R3 request ignored", smi_o, 1'b0);
    step(1);
    check("R3 request still ignored", smi_o, 1'b0);
    smm_req = 1'b0; smm_act = 1'b0;
    step(2);

    // R4 flush configurations
    enter_idle(1'b0);
    cfg_overlap = 1'b1;
    enter_idle(1'b1);
    cfg_overlap = 1'b0; cfg_cacheable = 1'b1;
    enter_idle(1'b1);
    cfg_cacheable = 1'b0;

    // R6 single transfer in flight
    bus_start = 1'b1; bus_burst = 1'b0;
    step(1);
    bus_start = 1'b0; smm_req = 1'b1;
    step(1);
    smm_req = 1'b0;
    check("R6 smi up", smi_o, 1'b1);
    check("R6 ewbe held low", ewbe_o, 1'b0);
    step(1);
    check("R6 ewbe still low", ewbe_o, 1'b0);
    bus_rdy = 1'b1;
    #1;
    check("R6 ewbe with last rdy", ewbe_o, 1'b1);
    step(1);
    bus_rdy = 1'b0;
    #1;
    check("R6 ewbe after rdy", ewbe_o, 1'b1);
    smm_act = 1'b1;
    step(1);
    smm_act = 1'b0;
    step(2);

    // R7 burst in flight
    bus_start = 1'b1; bus_burst = 1'b1;
    step(1);
    bus_start = 1'b0; bus_burst = 1'b0; smm_req = 1'b1;
    step(1);
    smm_req = 1'b0;
    check("R7 ewbe low at entry", ewbe_o, 1'b0);
    for (int k = 0; k < 3; k++) begin
      bus_rdy = 1'b1;
      #1;
      check("R7 ewbe low before fourth rdy", ewbe_o, 1'b0);
      step(1);
    end
    #1;
    check("R7 ewbe with fourth rdy", ewbe_o, 1'b1);
    step(1);
    bus_rdy = 1'b0;
    #1;
    check("R7 ewbe after burst", ewbe_o, 1'b1);
    smm_act = 1'b1;
    step(1);
    smm_act = 1'b0;
    step(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule